// File: doc/BRIEF.md
# Vector Length Set Execution Unit

This unit carries out the instruction that sets the maximum vector length (MVL) and the current vector length (VL) in a scalar core with a vector extension. It takes the 32-bit instruction word, the value of the source register named by RA, the count register and the current vector state register. One clock edge later it presents the rewritten state register, a destination register write and a condition field write. It also presents a strobe that asks the core to set the summary-overflow bit.

VL has three possible sources: a 7-bit immediate held as length minus one, the RA value, or the count register. Which one is used depends on whether the RA and RT register numbers are zero. The chosen length is saturated to 7 bits and then limited to MVL. Any loss in that process is reported as overflow. The condition field describes the resulting VL rather than the destination register. The unit also updates two mode bits in the state register.

Top module: `vlset_unit`

## Requirements
- R1: The unit acts only when instr[31:26] equals PRI_OP (default 22) and instr[5:1] equals EXT_OP (default 27). On any other word, one cycle later rt_we, cr_we and so_we are 0, and state_out equals state_in from the previous cycle.
- R2: The instruction word is laid out as rt=instr[25:21], ra=instr[20:16], imm=instr[15:9], ms=instr[8], vs=instr[7], vf=instr[6] and rc=instr[0]. MVL lives in state[63:57]. With ms=1 the new MVL is imm+1. With ms=0 MVL is kept.
- R3: VL lives in state[56:50]. With vs=0, VL is kept unchanged with no limit applied, and only an MVL immediate can cause overflow.
- R4: With vs=1, the VL source is chosen as follows: the RA value when ra≠0; the count register when ra=0 and rt≠0; imm+1 when ra=0 and rt=0.
- R5: An RA or count value above 127 (unsigned) is replaced by 127 and raises overflow.
- R6: When vs=1, a VL above the new MVL is replaced by MVL and raises overflow.
- R7: An immediate of 127 (a sum of 128) saturates to 127 and raises overflow, whether it is used for MVL or for VL.
- R8: With rt≠0, rt_we is 1 and rt_data is VL zero-extended to 64 bits. With rt=0, rt_we is 0 and rt_data is 0.
- R9: On a match, state bit 0 takes vf and state bit 1 is cleared. All bits outside MVL, VL and bits 0 and 1 pass through unchanged.
- R10: With rc=1, cr_we is 1 and cr_field is {LT,GT,EQ,SO} on bits 3..0. LT is 0, GT is (VL≠0), EQ is (VL=0) and SO is overflow. With rc=0, cr_we is 0 and cr_field is 0.
- R11: so_we is 1 only when rc=1 and overflow occurred.
- R12: All outputs are registered with a latency of one cycle. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| ra_val | input | XLEN | Value of register RA |
| ctr_val | input | XLEN | Count register value |
| state_in | input | XLEN | Current vector state register |
| state_out | output | XLEN | Updated vector state register |
| rt_we | output | 1 | Destination register write enable |
| rt_data | output | XLEN | Destination register write data |
| cr_we | output | 1 | Condition field 0 write enable |
| cr_field | output | 4 | Condition field value {LT,GT,EQ,SO} |
| so_we | output | 1 | Request to set summary overflow |

## Verification
The bench builds the unit with its defaults: XLEN=64, PRI_OP=22 and EXT_OP=27. With a 64-bit RA and count register, values far above the 7-bit length can be driven directly, so the saturation at 127 can be reached. The 7-bit immediate reaches the sum of 128 with the single encoding 127. Mismatching opcodes in either field let the pass-through path be compared against the full update.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
  localparam int INSN_W = 32;
  localparam int LEN_W  = 7;
  localparam int CR_W   = 4;

  typedef struct packed {
    logic [5:0]       po;
    logic [4:0]       rt;
    logic [4:0]       ra;
    logic [LEN_W-1:0] imm;
    logic             ms;
    logic             vs;
    logic             vf;
    logic [4:0]       xo;
    logic             rc;
  } insn_t;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_RA   = 2'd1,
    SRC_CTR  = 2'd2,
    SRC_IMM  = 2'd3
  } vl_src_e;

  // Condition field built from a resulting length and the overflow flag.
  function automatic logic [CR_W-1:0] cr_of(input logic [LEN_W-1:0] len, input logic ovf);
    return {1'b0, (len != '0), (len == '0), ovf};
  endfunction
endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
  import vlset_pkg::*;
#(
  parameter logic [5:0] PRI_OP = 6'd22,
  parameter logic [4:0] EXT_OP = 5'd27
) (
  input  logic [INSN_W-1:0] instr,
  output insn_t             fields,
  output logic              hit,
  output logic              ra_zero,
  output logic              rt_zero
);
  assign fields  = insn_t'(instr);
  assign hit     = (fields.po == PRI_OP) && (fields.xo == EXT_OP);
  assign ra_zero = (fields.ra == 5'd0);
  assign rt_zero = (fields.rt == 5'd0);
endmodule

// File: rtl/vlset_sat.sv
module vlset_sat #(
  parameter int W     = 64,
  parameter int LEN_W = 7
) (
  input  logic [W-1:0]     value,
  output logic [LEN_W-1:0] len,
  output logic             over
);
  generate
    if (W > LEN_W) begin : g_wide
      assign over = |value[W-1:LEN_W];
      assign len  = over ? {LEN_W{1'b1}} : value[LEN_W-1:0];
    end else begin : g_narrow
      assign over = 1'b0;
      assign len  = LEN_W'(value);
    end
  endgenerate
endmodule

// File: rtl/vlset_len_calc.sv
module vlset_len_calc
  import vlset_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             ms,
  input  logic             vs,
  input  logic             ra_zero,
  input  logic             rt_zero,
  input  logic [LEN_W-1:0] imm_field,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [LEN_W-1:0] mvl_old,
  input  logic [LEN_W-1:0] vl_old,
  output logic [LEN_W-1:0] mvl_new,
  output logic [LEN_W-1:0] vl_new,
  output logic             ovf
);
  logic [LEN_W:0]   imm_wide;
  logic [LEN_W-1:0] imm_len, ra_len, ctr_len, raw;
  logic             imm_over, ra_over, ctr_over, raw_over, clamp_hit;
  vl_src_e          src;

  assign imm_wide = {1'b0, imm_field} + (LEN_W+1)'(1);

  vlset_sat #(.W(LEN_W+1), .LEN_W(LEN_W)) u_imm_sat (.value(imm_wide), .len(imm_len), .over(imm_over));
  vlset_sat #(.W(XLEN),    .LEN_W(LEN_W)) u_ra_sat  (.value(ra_val),   .len(ra_len),  .over(ra_over));
  vlset_sat #(.W(XLEN),    .LEN_W(LEN_W)) u_ctr_sat (.value(ctr_val),  .len(ctr_len), .over(ctr_over));

  always_comb begin
    if (!vs)           src = SRC_KEEP;
    else if (!ra_zero) src = SRC_RA;
    else if (!rt_zero) src = SRC_CTR;
    else               src = SRC_IMM;
  end

  always_comb begin
    case (src)
      SRC_RA:  begin raw = ra_len;  raw_over = ra_over;  end
      SRC_CTR: begin raw = ctr_len; raw_over = ctr_over; end
      SRC_IMM: begin raw = imm_len; raw_over = imm_over; end
      default: begin raw = vl_old;  raw_over = 1'b0;     end
    endcase
  end

  assign mvl_new   = ms ? imm_len : mvl_old;
  assign clamp_hit = (src != SRC_KEEP) && (raw > mvl_new);
  assign vl_new    = clamp_hit ? mvl_new : raw;
  assign ovf       = (ms && imm_over) || raw_over || clamp_hit;
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vlset_pkg::*;
#(
  parameter int         XLEN   = 64,
  parameter logic [5:0] PRI_OP = 6'd22,
  parameter logic [4:0] EXT_OP = 5'd27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   ctr_val,
  input  logic [XLEN-1:0]   state_in,
  output logic [XLEN-1:0]   state_out,
  output logic              rt_we,
  output logic [XLEN-1:0]   rt_data,
  output logic              cr_we,
  output logic [CR_W-1:0]   cr_field,
  output logic              so_we
);
  localparam int MVL_HI  = XLEN - 1;
  localparam int MVL_LO  = XLEN - LEN_W;
  localparam int VL_HI   = MVL_LO - 1;
  localparam int VL_LO   = XLEN - 2*LEN_W;
  localparam int VF_BIT  = 0;
  localparam int PER_BIT = 1;

  insn_t            fields;
  logic             hit, ra_zero, rt_zero, dec_vs;
  logic [LEN_W-1:0] mvl_new, vl_new;
  logic             ovf_any;
  logic [XLEN-1:0]  state_nxt;

  vlset_decode #(.PRI_OP(PRI_OP), .EXT_OP(EXT_OP)) u_dec (
    .instr(instr), .fields(fields), .hit(hit), .ra_zero(ra_zero), .rt_zero(rt_zero)
  );

  assign dec_vs = fields.vs;

  vlset_len_calc #(.XLEN(XLEN)) u_len (
    .ms(fields.ms), .vs(fields.vs), .ra_zero(ra_zero), .rt_zero(rt_zero),
    .imm_field(fields.imm), .ra_val(ra_val), .ctr_val(ctr_val),
    .mvl_old(state_in[MVL_HI:MVL_LO]), .vl_old(state_in[VL_HI:VL_LO]),
    .mvl_new(mvl_new), .vl_new(vl_new), .ovf(ovf_any)
  );

  always_comb begin
    state_nxt = state_in;
    if (hit) begin
      state_nxt[MVL_HI:MVL_LO] = mvl_new;
      state_nxt[VL_HI:VL_LO]   = vl_new;
      state_nxt[PER_BIT]       = 1'b0;
      state_nxt[VF_BIT]        = fields.vf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_out <= '0;
      rt_we     <= 1'b0;
      rt_data   <= '0;
      cr_we     <= 1'b0;
      cr_field  <= '0;
      so_we     <= 1'b0;
    end else begin
      state_out <= state_nxt;
      rt_we     <= hit && !rt_zero;
      rt_data   <= (hit && !rt_zero) ? XLEN'(vl_new) : '0;
      cr_we     <= hit && fields.rc;
      cr_field  <= (hit && fields.rc) ? cr_of(vl_new, ovf_any) : '0;
      so_we     <= hit && fields.rc && ovf_any;
    end
  end
endmodule

// File: rtl/vlset_checker.sv
module vlset_checker #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit,
  input logic            dec_vs,
  input logic [XLEN-1:0] state_out,
  input logic            rt_we,
  input logic [XLEN-1:0] rt_data,
  input logic            cr_we,
  input logic [3:0]      cr_field,
  input logic            so_we
);
  localparam int MVL_LO = XLEN - LEN_W;
  localparam int VL_LO  = XLEN - 2*LEN_W;

  logic [LEN_W-1:0] out_vl, out_mvl;
  assign out_mvl = state_out[XLEN-1:MVL_LO];
  assign out_vl  = state_out[MVL_LO-1:VL_LO];

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!rt_we && !cr_we && !so_we)); // R1
  AST_VL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dec_vs) |=> (out_vl <= out_mvl)); // R6
  AST_PERSIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !state_out[1]); // R9
  AST_EQ_FROM_VL: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (cr_field[1] == (out_vl == '0)) && (cr_field[2] != cr_field[1])); // R10
  AST_LT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> !cr_field[3]); // R10
  AST_SO_WITH_CR: assert property (@(posedge clk) disable iff (!rst_n)
    so_we |-> (cr_we && cr_field[0])); // R11
  AST_RT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> (rt_data == XLEN'(out_vl))); // R8
endmodule

bind vlset_unit vlset_checker #(.XLEN(XLEN), .LEN_W(vlset_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .dec_vs(dec_vs), .state_out(state_out),
  .rt_we(rt_we), .rt_data(rt_data), .cr_we(cr_we), .cr_field(cr_field), .so_we(so_we)
);

// File: tb/vlset_unit_tb_top.sv
module vlset_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] st;
    logic        rt_we;
    logic [63:0] rt_data;
    logic        cr_we;
    logic [3:0]  cr;
    logic        so_we;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] ra_val = '0, ctr_val = '0, state_in = '0;
  logic [63:0] state_out, rt_data;
  logic        rt_we, cr_we, so_we;
  logic [3:0]  cr_field;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;
  exp_t q[$];
  string tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlset_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ra_val(ra_val), .ctr_val(ctr_val),
    .state_in(state_in), .state_out(state_out), .rt_we(rt_we), .rt_data(rt_data),
    .cr_we(cr_we), .cr_field(cr_field), .so_we(so_we)
  );

  function automatic logic [31:0] mk(int rt, int ra, int svi, bit ms, bit vs, bit vf, bit rc,
                                     int po = 22, int xo = 27);
    return {6'(po), 5'(rt), 5'(ra), 7'(svi), ms, vs, vf, 5'(xo), rc};
  endfunction

  function automatic logic [63:0] mkst(int mvl, int vl, logic [63:0] rest);
    logic [63:0] s;
    s = rest;
    s[63:57] = 7'(mvl);
    s[56:50] = 7'(vl);
    return s;
  endfunction

  // Independent reference model written from the requirements.
  function automatic exp_t model(logic [31:0] ins, logic [63:0] ra, logic [63:0] ctr, logic [63:0] st);
    exp_t e;
    int rt, ran, immv, mvl, vl;
    bit ms, vs, vf, rc, io, ovf;
    longint unsigned w;
    e = '0;
    rt = int'(ins[25:21]); ran = int'(ins[20:16]);
    ms = ins[8]; vs = ins[7]; vf = ins[6]; rc = ins[0];
    if (ins[31:26] != 6'd22 || ins[5:1] != 5'd27) begin
      e.st = st;
      return e;
    end
    immv = int'(ins[15:9]) + 1;
    io = (immv > 127);
    if (io) immv = 127;
    mvl = ms ? immv : int'(st[63:57]);
    ovf = ms && io;
    vl = int'(st[56:50]);
    if (vs) begin
      if (ran != 0 || rt != 0) begin
        w = (ran != 0) ? ra : ctr;
        if (w > 127) begin vl = 127; ovf = 1; end
        else vl = int'(w);
      end else begin
        vl = immv;
        if (io) ovf = 1;
      end
      if (vl > mvl) begin vl = mvl; ovf = 1; end
    end
    e.st = st;
    e.st[63:57] = 7'(mvl);
    e.st[56:50] = 7'(vl);
    e.st[1] = 1'b0;
    e.st[0] = vf;
    e.rt_we = (rt != 0);
    e.rt_data = (rt != 0) ? 64'(vl) : 64'd0;
    e.cr_we = rc;
    e.cr = rc ? {1'b0, vl != 0, vl == 0, ovf} : 4'd0;
    e.so_we = rc && ovf;
    return e;
  endfunction

  task automatic issue(logic [31:0] ins, logic [63:0] ra, logic [63:0] ctr, logic [63:0] st, string tag);
    @(negedge clk);
    instr = ins; ra_val = ra; ctr_val = ctr; state_in = st;
    q.push_back(model(ins, ra, ctr, st));
    tq.push_back(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Monitor: compares one expected item per cycle, two time units after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e, a;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        a = {state_out, rt_we, rt_data, cr_we, cr_field, so_we};
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if ({state_out, rt_we, rt_data, cr_we, cr_field, so_we} !== '0) begin
      n_fail++;
      $display("FAIL R12 reset actual=%h expected=0", {state_out, rt_we, rt_data, cr_we, cr_field, so_we});
    end
    rst_n = 1'b1;

    issue(mk(3, 4, 5, 1, 1, 1, 1, 22, 26), 64'd9, 64'd9, mkst(9, 3, 64'h0000_0ABC_DEF0_1233), "R1 wrong xo");
    issue(mk(3, 0, 5, 1, 1, 1, 1, 21, 27), 64'd9, 64'd9, mkst(12, 7, 64'h0002_1234_5678_0002), "R1 wrong po");
    issue(mk(0, 0, 7, 0, 1, 0, 1), 64'd0, 64'd0, mkst(16, 2, 64'd0), "R4 imm source");
    issue(mk(0, 0, 7, 1, 0, 0, 1), 64'd0, 64'd0, mkst(20, 30, 64'd0), "R2 R3 mvl from imm, vl kept");
    issue(mk(5, 4, 0, 0, 1, 0, 0), 64'd5, 64'd99, mkst(10, 0, 64'd0), "R4 R8 ra source");
    issue(mk(5, 0, 0, 0, 1, 0, 1), 64'd3, 64'd20, mkst(10, 0, 64'd0), "R4 R6 ctr clamp");
    issue(mk(2, 0, 0, 0, 1, 0, 1), 64'd3, 64'd1000, mkst(127, 0, 64'd0), "R5 ctr saturate");
    issue(mk(2, 7, 0, 0, 1, 0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, mkst(127, 0, 64'd0), "R5 ra saturate");
    issue(mk(6, 4, 0, 0, 1, 0, 1), 64'd0, 64'd50, mkst(40, 9, 64'd0), "R10 eq on zero vl");
    issue(mk(0, 0, 127, 1, 1, 0, 1), 64'd0, 64'd0, mkst(3, 3, 64'd0), "R7 imm 128");
    issue(mk(0, 0, 127, 1, 0, 0, 1), 64'd0, 64'd0, mkst(3, 3, 64'd0), "R7 imm 128 mvl only");
    issue(mk(1, 0, 0, 0, 1, 0, 0), 64'd0, 64'd50, mkst(10, 0, 64'd0), "R11 overflow without rc");
    issue(mk(0, 0, 3, 0, 0, 1, 0), 64'd0, 64'd0, mkst(5, 4, 64'h0000_1357_9BDF_F00E), "R9 vf set persist cleared");
    issue(mk(0, 9, 0, 0, 1, 0, 1), 64'd6, 64'd77, mkst(30, 0, 64'd0), "R8 R4 rt zero ra source");
    issue(mk(1, 2, 3, 1, 1, 0, 1), 64'd40, 64'd0, mkst(100, 0, 64'd0), "R6 clamp to new mvl");
    issue(mk(0, 0, 0, 0, 1, 1, 1), 64'd0, 64'd0, mkst(8, 5, 64'd2), "R2 imm zero means one");
    issue(mk(4, 3, 0, 0, 1, 0, 1), 64'd3, 64'd60, mkst(64, 0, 64'd0), "R4 ra wins over ctr");
    issue(32'd0, 64'd0, 64'd0, 64'h1111_2222_3333_4444, "R1 R12 idle word");

    @(negedge clk);
    instr = '0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule